// File: doc/BRIEF.md
# Non-pipelined bus cycle sequencer

This block is the bus-master side of a processor-style external bus that runs without address pipelining. An internal requester offers one transfer at a time. A transfer carries a word-aligned address, four byte enables, a direction flag and write data. The sequencer turns each accepted transfer into one or two external bus cycles.

A cycle opens with a single address clock. In that clock the active-low address strobe is low and the new address, byte enables and direction appear on the bus. The data clock follows. It repeats as a wait state until the ready input is sampled low. Bus ownership can be handed to another master through a hold request and acknowledge pair, but only at a cycle boundary.

When the slave reports a 16-bit bus and both halves of the word carry enabled bytes, the transfer is finished as a second ordinary cycle. That second cycle moves the upper half onto the low lanes. The requester sees one completion pulse carrying the reassembled read data.

Top module: `nonpipe_bus_master`

## Requirements
- R1: While reset is held, addrStrobeN is 1, holdAck is 0, doneValid is 0 and reqReady is 0; the block leaves reset idle.
- R2: When idle or in hold acknowledge, a high holdReq wins over a pending request. Without holdReq, a high reqValid is accepted: reqReady is 1 in that clock and addrStrobeN goes low in the next clock.
- R3: addrStrobeN is 0 in exactly the first clock of each bus cycle. That clock is always followed by a data clock.
- R4: In a data clock with readyN high, the next clock is another data clock. busAddr, busBe, busWrite and busWdata stay unchanged through all such wait clocks.
- R5: A data clock with readyN low that ends the transfer raises doneValid for that one clock, with doneRdata valid. The next state is hold acknowledge if holdReq is 1. Otherwise it is a new address clock if reqValid is 1 (which is then accepted), and idle if not.
- R6: holdAck is 1 only in the hold acknowledge state. It stays 1 while holdReq is 1. A holdReq raised during a bus cycle is granted only after that transfer's final acknowledged data clock. On release the block goes to an address clock if a request is pending, and to idle if none is.
- R7: A second cycle is needed when busSize16N is sampled low together with readyN low in the first half, and the transfer has enabled bytes in both busBe[1:0] and busBe[3:2]. The first half then raises no doneValid and is followed at once by an address clock, even with holdReq high. In that second cycle busAddr is the first address plus 2, busBe is {2'b00, first busBe[3:2]}, and busWdata carries the original bits [31:16] on bits [15:0] with zeros above.
- R8: For a split transfer, doneRdata is {busRdata[15:0] of the second cycle, busRdata[15:0] of the first cycle}. For a single-cycle transfer it is busRdata as sampled on the acknowledged clock.
- R9: busSize16N has no effect in a second half, or when either half of the byte enables is all zero. Such a transfer completes in one cycle.
- R10: The shortest bus cycle is two clocks long: one address clock, then one data clock with readyN low that raises doneValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Requester offers a transfer; held until accepted |
| reqReady | output | 1 | Transfer accepted in this clock |
| reqAddr | input | ADDR_W | Word-aligned transfer address |
| reqBe | input | DATA_W/8 | Byte enables of the transfer |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqWdata | input | DATA_W | Write data |
| doneValid | output | 1 | One-clock completion pulse |
| doneRdata | output | DATA_W | Read data returned with doneValid |
| holdReq | input | 1 | Another master asks for the bus |
| holdAck | output | 1 | Bus handed over |
| addrStrobeN | output | 1 | Active-low address strobe, low in the address clock |
| busAddr | output | ADDR_W | Bus address |
| busBe | output | DATA_W/8 | Bus byte enables |
| busWrite | output | 1 | Bus direction |
| busWdata | output | DATA_W | Bus write data |
| busRdata | input | DATA_W | Bus read data |
| readyN | input | 1 | Active-low cycle acknowledge from the slave |
| busSize16N | input | 1 | Active-low 16-bit bus indication |

## Verification
A wrong state register shows up within a clock. The strobe, holdAck, reqReady and doneValid are all decoded from the state and the current inputs, so a missed wait state or a hold granted mid-cycle produces a mismatch in the same or the next clock. Faults in the split datapath are subtler. A wrong address step, lane shift or kept low half appears only in the second cycle's bus fields or at the completion pulse, so the bench compares those fields in every address and data clock and the read data at every completion.

// File: rtl/nbm_pkg.sv
package nbm_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_ADDR = 2'd1,
    BUS_DATA = 2'd2,
    BUS_HOLD = 2'd3
  } busState_t;

  typedef struct packed {
    logic loadNew;
    logic loadSecond;
  } dpCtl_t;

endpackage

// File: rtl/nbm_ctrl.sv
module nbm_ctrl
  import nbm_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      holdReq,
  input  logic      readyN,
  input  logic      busSize16N,
  input  logic      splitAllowed,
  output busState_t state,
  output dpCtl_t    dpCtl,
  output logic      reqReady,
  output logic      doneValid,
  output logic      addrStrobeN,
  output logic      holdAck
);

  busState_t stateNext;
  logic ackNow;
  logic needSecond;
  logic finalAck;
  logic boundary;
  logic takeNew;

  always_comb begin
    ackNow     = (state == BUS_DATA) && !readyN;
    needSecond = ackNow && !busSize16N && splitAllowed;
    finalAck   = ackNow && !needSecond;
    boundary   = (state == BUS_IDLE) || (state == BUS_HOLD) || finalAck;
    takeNew    = boundary && !holdReq && reqValid;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      BUS_IDLE: begin
        if (holdReq)       stateNext = BUS_HOLD;
        else if (reqValid) stateNext = BUS_ADDR;
      end
      BUS_ADDR: stateNext = BUS_DATA;
      BUS_DATA: begin
        if (readyN)          stateNext = BUS_DATA;
        else if (needSecond) stateNext = BUS_ADDR;
        else if (holdReq)    stateNext = BUS_HOLD;
        else if (reqValid)   stateNext = BUS_ADDR;
        else                 stateNext = BUS_IDLE;
      end
      BUS_HOLD: begin
        if (holdReq)       stateNext = BUS_HOLD;
        else if (reqValid) stateNext = BUS_ADDR;
        else               stateNext = BUS_IDLE;
      end
      default: stateNext = BUS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= BUS_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    dpCtl.loadNew    = takeNew;
    dpCtl.loadSecond = needSecond;
    reqReady         = takeNew;
    doneValid        = finalAck;
    addrStrobeN      = (state != BUS_ADDR);
    holdAck          = (state == BUS_HOLD);
  end

endmodule

// File: rtl/nbm_dpath.sv
module nbm_dpath
  import nbm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtl_t              dpCtl,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W/8-1:0] reqBe,
  input  logic                reqWrite,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W-1:0]   busRdata,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [DATA_W/8-1:0] busBe,
  output logic                busWrite,
  output logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   doneRdata,
  output logic                splitAllowed
);

  localparam int BE_W    = DATA_W / 8;
  localparam int HALF_W  = DATA_W / 2;
  localparam int HALF_BE = BE_W / 2;

  logic [ADDR_W-1:0] addrQ;
  logic [BE_W-1:0]   beQ;
  logic              writeQ;
  logic [DATA_W-1:0] wdataQ;
  logic [HALF_W-1:0] lowQ;
  logic              secondQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      beQ     <= '0;
      writeQ  <= 1'b0;
      wdataQ  <= '0;
      lowQ    <= '0;
      secondQ <= 1'b0;
    end else if (dpCtl.loadNew) begin
      addrQ   <= reqAddr;
      beQ     <= reqBe;
      writeQ  <= reqWrite;
      wdataQ  <= reqWdata;
      secondQ <= 1'b0;
    end else if (dpCtl.loadSecond) begin
      addrQ   <= addrQ + ADDR_W'(HALF_BE);
      beQ     <= {{HALF_BE{1'b0}}, beQ[BE_W-1:HALF_BE]};
      wdataQ  <= {{HALF_W{1'b0}}, wdataQ[DATA_W-1:HALF_W]};
      lowQ    <= busRdata[HALF_W-1:0];
      secondQ <= 1'b1;
    end
  end

  always_comb begin
    splitAllowed = !secondQ && (|beQ[BE_W-1:HALF_BE]) && (|beQ[HALF_BE-1:0]);
    doneRdata    = secondQ ? {busRdata[HALF_W-1:0], lowQ} : busRdata;
    busAddr      = addrQ;
    busBe        = beQ;
    busWrite     = writeQ;
    busWdata     = wdataQ;
  end

endmodule

// File: rtl/nonpipe_bus_master.sv
module nonpipe_bus_master
  import nbm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W/8-1:0] reqBe,
  input  logic                reqWrite,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                doneValid,
  output logic [DATA_W-1:0]   doneRdata,
  input  logic                holdReq,
  output logic                holdAck,
  output logic                addrStrobeN,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [DATA_W/8-1:0] busBe,
  output logic                busWrite,
  output logic [DATA_W-1:0]   busWdata,
  input  logic [DATA_W-1:0]   busRdata,
  input  logic                readyN,
  input  logic                busSize16N
);

  busState_t state;
  dpCtl_t    dpCtl;
  logic      splitAllowed;

  nbm_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .holdReq      (holdReq),
    .readyN       (readyN),
    .busSize16N   (busSize16N),
    .splitAllowed (splitAllowed),
    .state        (state),
    .dpCtl        (dpCtl),
    .reqReady     (reqReady),
    .doneValid    (doneValid),
    .addrStrobeN  (addrStrobeN),
    .holdAck      (holdAck)
  );

  nbm_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .dpCtl        (dpCtl),
    .reqAddr      (reqAddr),
    .reqBe        (reqBe),
    .reqWrite     (reqWrite),
    .reqWdata     (reqWdata),
    .busRdata     (busRdata),
    .busAddr      (busAddr),
    .busBe        (busBe),
    .busWrite     (busWrite),
    .busWdata     (busWdata),
    .doneRdata    (doneRdata),
    .splitAllowed (splitAllowed)
  );

endmodule

// File: rtl/nbm_checker.sv
module nbm_checker
  import nbm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BE_W   = 4
) (
  input logic              clk,
  input logic              rstN,
  input busState_t         state,
  input logic              readyN,
  input logic              holdReq,
  input logic              holdAck,
  input logic              doneValid,
  input logic              addrStrobeN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [BE_W-1:0]   busBe,
  input logic              busWrite
);

  p_idle_hold_wins_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == BUS_IDLE && holdReq) |=> holdAck);

  p_strobe_one_clock_r3: assert property (@(posedge clk) disable iff (!rstN)
    !addrStrobeN |=> (addrStrobeN && state == BUS_DATA));

  p_wait_keeps_bus_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == BUS_DATA && readyN) |=>
      (state == BUS_DATA && $stable(busAddr) && $stable(busBe) && $stable(busWrite)));

  p_done_needs_ready_r5: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (state == BUS_DATA && !readyN));

  p_no_grant_mid_cycle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == BUS_DATA && readyN) |=> !holdAck);

  p_grant_after_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && holdReq) |=> holdAck);

  p_second_half_follows_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == BUS_DATA && !readyN && !doneValid) |=>
      (!addrStrobeN && busAddr == $past(busAddr) + ADDR_W'(BE_W / 2)));

endmodule

bind nonpipe_bus_master nbm_checker #(
  .ADDR_W (ADDR_W),
  .BE_W   (DATA_W / 8)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .state       (state),
  .readyN      (readyN),
  .holdReq     (holdReq),
  .holdAck     (holdAck),
  .doneValid   (doneValid),
  .addrStrobeN (addrStrobeN),
  .busAddr     (busAddr),
  .busBe       (busBe),
  .busWrite    (busWrite)
);

// File: tb/nonpipe_bus_master_tb.sv
`timescale 1ns/1ps
module nonpipe_bus_master_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqAddr = '0;
  logic [3:0]  reqBe = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqWdata = '0;
  logic        doneValid;
  logic [31:0] doneRdata;
  logic        holdReq = 1'b0;
  logic        holdAck;
  logic        addrStrobeN;
  logic [31:0] busAddr;
  logic [3:0]  busBe;
  logic        busWrite;
  logic [31:0] busWdata;
  logic [31:0] busRdata = '0;
  logic        readyN = 1'b1;
  logic        busSize16N = 1'b1;

  always #2 clk = ~clk;

  nonpipe_bus_master u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqBe(reqBe), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .doneValid(doneValid), .doneRdata(doneRdata), .holdReq(holdReq),
    .holdAck(holdAck), .addrStrobeN(addrStrobeN), .busAddr(busAddr),
    .busBe(busBe), .busWrite(busWrite), .busWdata(busWdata),
    .busRdata(busRdata), .readyN(readyN), .busSize16N(busSize16N)
  );

  int checks = 0;
  int failures = 0;
  int cycle = 0;

  // reference model: 0 idle, 1 address clock, 2 data clock, 3 hold
  int          mState = 0;
  logic [31:0] mAddr = '0;
  logic [3:0]  mBe = '0;
  logic        mWrite = 1'b0;
  logic [31:0] mWdata = '0;
  logic        mSecond = 1'b0;
  logic [15:0] mLow = '0;
  logic        mPrevAddr = 1'b0;
  logic        takenLast = 1'b0;
  logic        ack, split, fin, take;
  logic [31:0] expRd;
  int          nState;
  string       tag;
  int          pReq, pWait, pBs16, pHold;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s cycle=%0d actual=%h expected=%h", what, cycle, act, exp);
    end
  endtask

  function automatic bit chance(input int pct);
    return ($urandom % 100) < pct;
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic run_cycle();
    @(negedge clk);
    cycle++;
    if (takenLast) reqValid = 1'b0;
    if (!reqValid && chance(pReq)) begin
      reqValid = 1'b1;
      reqAddr  = $urandom & 32'hFFFF_FFFC;
      case ($urandom % 4)
        0: reqBe = 4'hF;
        1: reqBe = 4'h3;
        2: reqBe = 4'hC;
        default: reqBe = 4'($urandom);
      endcase
      reqWrite = 1'($urandom);
      reqWdata = $urandom;
    end
    if (chance(pHold)) holdReq = ~holdReq;
    readyN     = chance(pWait);
    busSize16N = !chance(pBs16);
    busRdata   = $urandom;
    #1;
    ack   = (mState == 2) && !readyN;
    split = ack && !busSize16N && !mSecond && (mBe[3:2] != 2'b00) && (mBe[1:0] != 2'b00);
    fin   = ack && !split;
    take  = (mState == 0 || mState == 3 || fin) && !holdReq && reqValid;
    expRd = mSecond ? {busRdata[15:0], mLow} : busRdata;

    chk("R3 addrStrobeN", 64'(addrStrobeN), 64'(mState != 1));
    chk("R6 holdAck", 64'(holdAck), 64'(mState == 3));
    chk("R2 reqReady", 64'(reqReady), 64'(take));
    if (ack && !busSize16N && !split) tag = "R9 doneValid";
    else if (mPrevAddr)               tag = "R10 doneValid";
    else                              tag = "R5 doneValid";
    chk(tag, 64'(doneValid), 64'(fin));
    if (fin) chk(mSecond ? "R8 doneRdata" : "R5 doneRdata", 64'(doneRdata), 64'(expRd));
    if (mState == 1 || mState == 2) begin
      chk(mSecond ? "R7 busAddr"  : "R4 busAddr",  64'(busAddr),  64'(mAddr));
      chk(mSecond ? "R7 busBe"    : "R4 busBe",    64'(busBe),    64'(mBe));
      chk(mSecond ? "R7 busWrite" : "R4 busWrite", 64'(busWrite), 64'(mWrite));
      chk(mSecond ? "R7 busWdata" : "R4 busWdata", 64'(busWdata), 64'(mWdata));
    end

    case (mState)
      0: nState = holdReq ? 3 : (reqValid ? 1 : 0);
      1: nState = 2;
      2: nState = readyN ? 2 : (split ? 1 : (holdReq ? 3 : (reqValid ? 1 : 0)));
      default: nState = holdReq ? 3 : (reqValid ? 1 : 0);
    endcase
    if (take) begin
      mAddr = reqAddr; mBe = reqBe; mWrite = reqWrite; mWdata = reqWdata; mSecond = 1'b0;
    end else if (split) begin
      mAddr   = mAddr + 32'd2;
      mBe     = {2'b00, mBe[3:2]};
      mWdata  = {16'h0000, mWdata[31:16]};
      mLow    = busRdata[15:0];
      mSecond = 1'b1;
    end
    takenLast = take;
    mPrevAddr = (mState == 1);
    mState    = nState;
  endtask

  initial begin
    #(100000 * 4);
    checks++;
    failures++;
    $display("FAIL watchdog expired at cycle=%0d", cycle);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 addrStrobeN in reset", 64'(addrStrobeN), 64'd1);
    chk("R1 holdAck in reset", 64'(holdAck), 64'd0);
    chk("R1 doneValid in reset", 64'(doneValid), 64'd0);
    chk("R1 reqReady in reset", 64'(reqReady), 64'd0);
    rstN = 1'b1;
    for (int ph = 0; ph < 5; ph++) begin
      case (ph)
        0: begin pReq = 100; pWait = 0;  pBs16 = 0;  pHold = 0;  end
        1: begin pReq = 60;  pWait = 50; pBs16 = 0;  pHold = 0;  end
        2: begin pReq = 70;  pWait = 30; pBs16 = 60; pHold = 0;  end
        3: begin pReq = 60;  pWait = 30; pBs16 = 50; pHold = 20; end
        default: begin pReq = 30; pWait = 20; pBs16 = 50; pHold = 40; end
      endcase
      for (int i = 0; i < 400; i++) run_cycle();
    end
    summary();
    $finish;
  end

endmodule